// File: doc/BRIEF.md
# DRAM Error Capture and Interrupt Status Unit

This unit sits beside the datapath of a DRAM controller and records the faults that the datapath reports. Three kinds of fault arrive as single-cycle pulses: a corrected or uncorrectable ECC fault with its address, syndrome and access direction; a parity fault with its address and the byte lanes that failed; and an invalid-address fault with a tag naming the requester. ECC faults fill two capture slots, using whichever slot is free. A third fault only marks an overflow. Parity faults have one capture slot and their own overflow mark.

Each event sets a sticky bit in a status word. Software clears a bit by writing a one to it. A level interrupt to the processor stays high while any status bit is set. Software reads the status word and the capture slots through a small register port. A read returns its data one cycle after the request.

Top module: `memerr_status_unit`

## Requirements
- R1: After reset the status word reads 0 and `irq` is low. Status bits are: 0 ECC slot 0 filled, 1 ECC slot 1 filled, 2 ECC overflow, 3 address-region fault, 8 parity slot filled, 9 parity overflow. Every other bit always reads 0.
- R2: An ECC fault that arrives while bits 0 and 1 are both clear is captured in ECC slot 0 and sets bit 0.
- R3: An ECC fault that arrives while exactly one of bits 0 and 1 is set is captured in the slot whose bit is clear, and sets that bit. The other slot keeps its contents.
- R4: An ECC fault that arrives while bits 0 and 1 are both set sets bit 2 only. Both ECC slots keep their contents.
- R5: A parity fault that arrives while bit 8 is clear is captured in the parity slot and sets bit 8. A parity fault that arrives while bit 8 is set sets bit 9, and the parity slot keeps its contents.
- R6: The source tag is 2 bits wide, and tag bit 1 = 1 marks a direct memory port. An invalid-address fault sets bit 3 only when tag bit 1 is 1. Tags 00 and 01 come from internal buses and never change bit 3.
- R7: A write to offset 0 clears each status bit that has a 1 in the written data. Zero bits in the data leave their status bits unchanged. Writes to any other offset are ignored.
- R8: `irq` is high in exactly the cycles when the status word is nonzero.
- R9: When a hardware event sets a status bit in the same cycle that software clears that bit, the bit ends up set.
- R10: Register offsets (word index): 0 status; 1 ECC slot 0 address; 2 ECC slot 0 info; 3 ECC slot 1 address; 4 ECC slot 1 info; 5 parity address; 6 parity lane mask; 7 reads 0. An info word holds the syndrome in bits [SYN_W-1:0] and the direction in bit 31 (1 = write). A read pulse on `reg_rd_en` gives `reg_rd_valid` one cycle later, with the value the register held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_err_valid | input | 1 | One-cycle ECC fault pulse, at most one per cycle |
| ecc_err_addr | input | ADDR_W | Failing address of the ECC fault |
| ecc_err_syndrome | input | SYN_W | ECC syndrome |
| ecc_err_is_write | input | 1 | 1 if the faulting access was a write |
| par_err_valid | input | 1 | One-cycle parity fault pulse |
| par_err_addr | input | ADDR_W | Failing address of the parity fault |
| par_err_lanes | input | LANE_W | Mask of the failing byte lanes |
| region_err_valid | input | 1 | One-cycle invalid-address fault pulse |
| region_err_src | input | 2 | Requester tag; bit 1 set means direct memory port |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | 3 | Register word offset |
| reg_wr_data | input | 32 | Write data (write-one-to-clear for status) |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the request |
| reg_rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The assertions assume that each fault input is a clean single-cycle pulse, that at most one ECC fault arrives per cycle, and that the requester tag is valid whenever the address-fault pulse is high. The interrupt property assumes that no fault pulse is presented while reset is active. The stimulus drives every pulse for exactly one clock, presents one ECC fault at a time, and keeps all fault inputs low during reset. The only case that overlaps on purpose is a parity fault combined with a software clear in the same cycle, and that overlap is allowed by these assumptions.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int STAT_W  = 10;
  localparam int REG_W   = 32;
  localparam int OFS_W   = 3;

  localparam int B_ECC0  = 0;
  localparam int B_ECC1  = 1;
  localparam int B_ECCN  = 2;
  localparam int B_REGN  = 3;
  localparam int B_PAR0  = 8;
  localparam int B_PARN  = 9;

  localparam logic [STAT_W-1:0] STAT_IMPL =
    (STAT_W'(1) << B_ECC0) | (STAT_W'(1) << B_ECC1) | (STAT_W'(1) << B_ECCN) |
    (STAT_W'(1) << B_REGN) | (STAT_W'(1) << B_PAR0) | (STAT_W'(1) << B_PARN);

  typedef enum logic [OFS_W-1:0] {
    OFS_STATUS    = 3'd0,
    OFS_ECC0_ADDR = 3'd1,
    OFS_ECC0_INFO = 3'd2,
    OFS_ECC1_ADDR = 3'd3,
    OFS_ECC1_INFO = 3'd4,
    OFS_PAR_ADDR  = 3'd5,
    OFS_PAR_LANES = 3'd6,
    OFS_SPARE     = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/memerr_ecc_alloc.sv
// Chooses the ECC capture slot from the two fill bits.
module memerr_ecc_alloc (
  input  logic       fault,
  input  logic [1:0] filled,
  output logic [1:0] load,
  output logic       overflow
);
  always_comb begin
    load     = 2'b00;
    overflow = 1'b0;
    if (fault) begin
      if (!filled[0])      load[0]  = 1'b1;
      else if (!filled[1]) load[1]  = 1'b1;
      else                 overflow = 1'b1;
    end
  end
endmodule

// File: rtl/memerr_capture_reg.sv
// Holds a fault record; loads only when told to.
module memerr_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/memerr_status_reg.sv
// Sticky event bits: hardware set beats software clear.
module memerr_status_reg #(
  parameter int              W    = 10,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= set[b] | (bit_q & ~clr[b]);
      end
      assign q[b] = bit_q;
    end else begin : g_rsvd
      assign q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/memerr_reg_read.sv
// Registered read mux for the software port.
module memerr_reg_read
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [STAT_W-1:0]    status,
  input  logic [ADDR_W-1:0]    ecc_addr [2],
  input  logic [SYN_W-1:0]     ecc_syn  [2],
  input  logic                 ecc_wr   [2],
  input  logic [ADDR_W-1:0]    par_addr,
  input  logic [LANE_W-1:0]    par_lanes,
  output logic                 rd_valid,
  output logic [REG_W-1:0]     rd_data
);
  logic [REG_W-1:0] mux;
  logic [REG_W-1:0] info [2];

  for (genvar s = 0; s < 2; s++) begin : g_info
    always_comb begin
      info[s] = '0;
      info[s][SYN_W-1:0] = ecc_syn[s];
      info[s][REG_W-1]   = ecc_wr[s];
    end
  end

  always_comb begin
    mux = '0;
    case (reg_ofs_e'(ofs))
      OFS_STATUS:    mux = REG_W'(status);
      OFS_ECC0_ADDR: mux = REG_W'(ecc_addr[0]);
      OFS_ECC0_INFO: mux = info[0];
      OFS_ECC1_ADDR: mux = REG_W'(ecc_addr[1]);
      OFS_ECC1_INFO: mux = info[1];
      OFS_PAR_ADDR:  mux = REG_W'(par_addr);
      OFS_PAR_LANES: mux = REG_W'(par_lanes);
      default:       mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux;
    end
  end
endmodule

// File: rtl/memerr_status_unit.sv
module memerr_status_unit
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_err_valid,
  input  logic [ADDR_W-1:0] ecc_err_addr,
  input  logic [SYN_W-1:0]  ecc_err_syndrome,
  input  logic              ecc_err_is_write,
  input  logic              par_err_valid,
  input  logic [ADDR_W-1:0] par_err_addr,
  input  logic [LANE_W-1:0] par_err_lanes,
  input  logic              region_err_valid,
  input  logic [1:0]        region_err_src,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wr_data,
  output logic              reg_rd_valid,
  output logic [31:0]       reg_rd_data,
  output logic              irq
);
  localparam int ECC_LOG_W = ADDR_W + SYN_W + 1;
  localparam int PAR_LOG_W = ADDR_W + LANE_W;

  logic [STAT_W-1:0]    stat_q, stat_set, stat_clr;
  logic [1:0]           ecc_load;
  logic                 ecc_ovf;
  logic                 par_load;
  logic [ECC_LOG_W-1:0] ecc_rec;
  logic [ECC_LOG_W-1:0] ecc_log_q [2];
  logic [PAR_LOG_W-1:0] par_log_q;
  logic [ADDR_W-1:0]    ecc_addr_v [2];
  logic [SYN_W-1:0]     ecc_syn_v  [2];
  logic                 ecc_wr_v   [2];
  logic                 region_hit;

  assign ecc_rec = {ecc_err_is_write, ecc_err_syndrome, ecc_err_addr};

  memerr_ecc_alloc u_alloc (
    .fault    (ecc_err_valid),
    .filled   (stat_q[B_ECC1:B_ECC0]),
    .load     (ecc_load),
    .overflow (ecc_ovf)
  );

  for (genvar s = 0; s < 2; s++) begin : g_ecc_slot
    memerr_capture_reg #(.W(ECC_LOG_W)) u_log (
      .clk (clk), .rst_n (rst_n), .load (ecc_load[s]),
      .d   (ecc_rec), .q (ecc_log_q[s])
    );
    assign ecc_addr_v[s] = ecc_log_q[s][ADDR_W-1:0];
    assign ecc_syn_v[s]  = ecc_log_q[s][ADDR_W +: SYN_W];
    assign ecc_wr_v[s]   = ecc_log_q[s][ECC_LOG_W-1];
  end

  assign par_load = par_err_valid & ~stat_q[B_PAR0];

  memerr_capture_reg #(.W(PAR_LOG_W)) u_par_log (
    .clk (clk), .rst_n (rst_n), .load (par_load),
    .d   ({par_err_lanes, par_err_addr}), .q (par_log_q)
  );

  assign region_hit = region_err_valid & region_err_src[1];

  always_comb begin
    stat_set         = '0;
    stat_set[B_ECC0] = ecc_load[0];
    stat_set[B_ECC1] = ecc_load[1];
    stat_set[B_ECCN] = ecc_ovf;
    stat_set[B_REGN] = region_hit;
    stat_set[B_PAR0] = par_load;
    stat_set[B_PARN] = par_err_valid & stat_q[B_PAR0];
  end

  assign stat_clr = (reg_wr_en && reg_addr == OFS_STATUS) ?
                    (reg_wr_data[STAT_W-1:0] & STAT_IMPL) : '0;

  memerr_status_reg #(.W(STAT_W), .IMPL(STAT_IMPL)) u_status (
    .clk (clk), .rst_n (rst_n), .set (stat_set), .clr (stat_clr), .q (stat_q)
  );

  memerr_reg_read #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .LANE_W(LANE_W)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd_en),
    .ofs       (reg_addr),
    .status    (stat_q),
    .ecc_addr  (ecc_addr_v),
    .ecc_syn   (ecc_syn_v),
    .ecc_wr    (ecc_wr_v),
    .par_addr  (par_log_q[ADDR_W-1:0]),
    .par_lanes (par_log_q[PAR_LOG_W-1:ADDR_W]),
    .rd_valid  (reg_rd_valid),
    .rd_data   (reg_rd_data)
  );

  assign irq = |stat_q;
endmodule

// File: rtl/memerr_checker.sv
module memerr_checker #(
  parameter int EW = 41,
  parameter int PW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ecc_v,
  input logic [EW-1:0] ecc_in,
  input logic          par_v,
  input logic          reg_v,
  input logic [1:0]    reg_src,
  input logic          wr_en,
  input logic [2:0]    ofs,
  input logic [31:0]   wdata,
  input logic [9:0]    stat,
  input logic [EW-1:0] log0,
  input logic [EW-1:0] log1,
  input logic [PW-1:0] plog,
  input logic          irq
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7:4] == 4'b0);

  p_ecc_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_v && !stat[0] && !stat[1] |=> stat[0] && log0 == $past(ecc_in));

  p_ecc_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_v && stat[0] && !stat[1] |=> stat[1] && log1 == $past(ecc_in) && $stable(log0));

  p_ecc_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_v && stat[0] && stat[1] |=> stat[2] && $stable(log0) && $stable(log1));

  p_par_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_v && stat[8] |=> stat[9] && $stable(plog));

  p_region_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_v && reg_src[1]) && !stat[3] |=> !stat[3]);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ofs == 3'd0 && wdata[3] && !(reg_v && reg_src[1]) |=> !stat[3]);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ecc_v || par_v || reg_v));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    par_v && stat[8] && wr_en && ofs == 3'd0 && wdata[9] |=> stat[9]);
endmodule

bind memerr_status_unit memerr_checker #(.EW(ECC_LOG_W), .PW(PAR_LOG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ecc_v   (ecc_err_valid),
  .ecc_in  (ecc_rec),
  .par_v   (par_err_valid),
  .reg_v   (region_err_valid),
  .reg_src (region_err_src),
  .wr_en   (reg_wr_en),
  .ofs     (reg_addr),
  .wdata   (reg_wr_data),
  .stat    (stat_q),
  .log0    (ecc_log_q[0]),
  .log1    (ecc_log_q[1]),
  .plog    (par_log_q),
  .irq     (irq)
);

// File: tb/sim_memerr_status_unit.sv
`timescale 1ns/1ps
module sim_memerr_status_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_err_valid = 1'b0;
  logic [31:0] ecc_err_addr = '0;
  logic [7:0]  ecc_err_syndrome = '0;
  logic        ecc_err_is_write = 1'b0;
  logic        par_err_valid = 1'b0;
  logic [31:0] par_err_addr = '0;
  logic [7:0]  par_err_lanes = '0;
  logic        region_err_valid = 1'b0;
  logic [1:0]  region_err_src = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic        reg_rd_valid;
  logic [31:0] reg_rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  memerr_status_unit u0 (.*);

  // Monitor: pops expected read results as the design returns them.
  always @(negedge clk) begin
    if (reg_rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %h", reg_rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rd_data !== e) begin
          errors++;
          $display("FAIL %s got %h exp %h", t, reg_rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [2:0] ofs, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_rd_en = 1'b1; reg_addr = ofs;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] ofs, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = ofs; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic ecc(input logic [31:0] a, input logic [7:0] s, input logic w);
    ecc_err_valid = 1'b1; ecc_err_addr = a; ecc_err_syndrome = s; ecc_err_is_write = w;
    @(negedge clk);
    ecc_err_valid = 1'b0;
  endtask

  task automatic par(input logic [31:0] a, input logic [7:0] l, input logic clr, input logic [31:0] d);
    par_err_valid = 1'b1; par_err_addr = a; par_err_lanes = l;
    reg_wr_en = clr; reg_addr = 3'd0; reg_wr_data = d;
    @(negedge clk);
    par_err_valid = 1'b0; reg_wr_en = 1'b0;
  endtask

  task automatic region(input logic [1:0] src);
    region_err_valid = 1'b1; region_err_src = src;
    @(negedge clk);
    region_err_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq got %b exp %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, 32'h0, "R1 reset status");
    chk_irq(1'b0, "R1 reset");

    ecc(32'h1000_0040, 8'h5A, 1'b1);
    rd(3'd0, 32'h1, "R2 status after first ecc");
    rd(3'd1, 32'h1000_0040, "R2 slot0 addr");
    rd(3'd2, 32'h8000_005A, "R10 slot0 info");
    chk_irq(1'b1, "R8 after ecc");

    ecc(32'h2000_0080, 8'h3C, 1'b0);
    rd(3'd0, 32'h3, "R3 status after second ecc");
    rd(3'd3, 32'h2000_0080, "R3 slot1 addr");
    rd(3'd4, 32'h0000_003C, "R3 slot1 info");

    ecc(32'h3000_00C0, 8'h11, 1'b1);
    rd(3'd0, 32'h7, "R4 status overflow");
    rd(3'd1, 32'h1000_0040, "R4 slot0 held");
    rd(3'd3, 32'h2000_0080, "R4 slot1 held");

    wr(3'd0, 32'h1);
    rd(3'd0, 32'h6, "R7 clear bit0");
    ecc(32'h4000_0100, 8'h77, 1'b0);
    rd(3'd0, 32'h7, "R3 refill slot0");
    rd(3'd1, 32'h4000_0100, "R3 slot0 new addr");
    rd(3'd2, 32'h0000_0077, "R3 slot0 new info");
    rd(3'd3, 32'h2000_0080, "R3 slot1 untouched");

    wr(3'd0, 32'h0);
    rd(3'd0, 32'h7, "R7 write zero no effect");
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 32'h4000_0100, "R7 log write ignored");

    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R7 clear all");
    rd(3'd7, 32'h0, "R10 spare offset");
    chk_irq(1'b0, "R8 after clear");

    par(32'h5000_0010, 8'h0F, 1'b0, 32'h0);
    rd(3'd0, 32'h100, "R5 first parity");
    rd(3'd5, 32'h5000_0010, "R5 parity addr");
    rd(3'd6, 32'h0000_000F, "R5 parity lanes");
    par(32'h6000_0020, 8'hF0, 1'b0, 32'h0);
    rd(3'd0, 32'h300, "R5 parity overflow");
    rd(3'd5, 32'h5000_0010, "R5 parity addr held");
    rd(3'd6, 32'h0000_000F, "R5 parity lanes held");

    par(32'h7000_0030, 8'h01, 1'b1, 32'h200);
    rd(3'd0, 32'h300, "R9 set beats clear");
    wr(3'd0, 32'h300);
    rd(3'd0, 32'h0, "R7 clear parity bits");

    region(2'b00);
    region(2'b01);
    rd(3'd0, 32'h0, "R6 internal bus ignored");
    chk_irq(1'b0, "R6 internal no irq");
    region(2'b10);
    rd(3'd0, 32'h8, "R6 direct port 0");
    chk_irq(1'b1, "R8 region irq");
    wr(3'd0, 32'h8);
    region(2'b11);
    rd(3'd0, 32'h8, "R6 direct port 1");
    wr(3'd0, 32'h8);
    rd(3'd0, 32'h0, "R1 final status");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 reads missing got %0d exp 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule